// File: doc/BRIEF.md
# Up/Down Timer with Set/Clear Control Aliases

This block is a prescaled up/down counter with an 8-bit control register that software reaches through two addresses. A write to the setting address can only turn control bits on or queue a command. A write to the clearing address can only turn bits off or drop a queued command. Either way, a single bit changes without the register being read first. Both addresses return the same register contents.

The counter advances once per prescaler tick while it is running. It wraps between zero and an active period value, and each wrap gives a one-cycle overflow or underflow pulse. The period and compare values each have a software-written buffer and an active copy. A wrap moves the buffers into the active copies unless the update lock bit is set. A queued command always moves them. Queued commands (restart, halt, buffer load, count snapshot) wait for the next prescaler tick, run on that tick, and then read back as zero.

The register bus is a simple single-cycle write port and a combinational read port. Addresses: 0 = control (clearing alias), 1 = control (setting alias), 2 = period buffer, 3 = compare buffer, 4 = active period (read only), 5 = active compare (read only), 6 = count snapshot (read only), 7 reads zero.

Top module: `tmrsc_top`

## Requirements
- R1: After a synchronous active-low reset, the control register reads 0x00 at address 0 and at address 1. The count is 0 and the counter is halted. The active period reads 0xFF and the active compare reads 0x00.
- R2: A write to address 0 clears each of control bits 2 (one-shot), 1 (update lock) and 0 (down direction) that is written as 1. A bit written as 0 is unchanged, so writing 0x00 to either address changes nothing.
- R3: A write to address 1 sets each of control bits 4:0 that is written as 1. A nonzero value in bits 7:5 replaces the queued command. Both addresses read the resulting register.
- R4: A queued command (bits 7:5; 1 = restart, 2 = halt, 3 = buffer load, 4 = snapshot) runs on the next prescaler tick and then reads 0. A nonzero bits 7:5 value written to address 0 before that tick drops the command, and nothing is executed.
- R5: Writing 1s to bits 4:3 through address 1 sets those bits. Writing any nonzero value to bits 4:3 through address 0 clears both bits.
- R6: While running with bit 0 = 0, the count rises by one on each prescaler tick, which comes once every PRESC_DIV clock cycles. On a tick where the count is at or above the active period, it wraps to 0 and ovf_o pulses high for exactly one cycle.
- R7: While running with bit 0 = 1, the count falls by one per tick. On a tick at count 0, it reloads with the active period and unf_o pulses high for one cycle.
- R8: With bit 1 = 1, a wrap does not copy the period and compare buffers into the active registers. With bit 1 = 0, a wrap does copy them.
- R9: The buffer-load command (3) copies both buffers into the active registers on its tick, whatever bit 1 holds. Until some copy happens, writes to addresses 2 and 3 do not change addresses 4 and 5.
- R10: With bit 2 = 1, the counter wraps as usual at the next overflow or underflow and then halts. Later ticks leave the count unchanged.
- R11: Restart (1) loads 0 when counting up, or the active period when counting down, and starts the counter. Halt (2) stops the counter and keeps the count.
- R12: The snapshot command (4) stores the count value present on its tick in the register read at address 6.
- R13: If a command write to address 1 lands in the same cycle as the tick that runs an earlier queued command, the earlier command runs and the newly written command stays queued for the following tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_waddr | input | 3 | Write address |
| bus_wdata | input | 8 | Write data |
| bus_raddr | input | 3 | Read address |
| bus_rdata | output | 8 | Read data, combinational from bus_raddr |
| count_o | output | CNT_W | Live counter value |
| running_o | output | 1 | Counter is running |
| ovf_o | output | 1 | One-cycle pulse after an upward wrap |
| unf_o | output | 1 | One-cycle pulse after a downward wrap |
| tick_o | output | 1 | Prescaler tick; the following clock edge is a count edge |

## Verification
Command execution and a software command write can land in the same clock cycle. The bench waits until tick_o is high with a snapshot command queued, then drives a restart write through the setting alias in that same cycle. It then judges that the snapshot holds the count from that tick, that the control register reads back the restart, and that the restart takes effect only on the next tick. The other collision, a wrap that coincides with the update lock, is judged by reading the active period after an overflow with the lock set and again with it cleared.

// File: rtl/tmrsc_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the set/clear controlled timer.
// Assumes an 8-bit register bus and a 3-bit register address.
package tmrsc_pkg;

    localparam int BUS_W  = 8;
    localparam int ADDR_W = 3;

    // Queued command codes held in control bits 7:5.
    typedef enum logic [2:0] {
        CMD_NONE    = 3'd0,
        CMD_RESTART = 3'd1,
        CMD_HALT    = 3'd2,
        CMD_LOAD    = 3'd3,
        CMD_SNAP    = 3'd4
    } cmd_e;

    // Control register layout, most significant field first.
    typedef struct packed {
        logic [2:0] cmd;
        logic [1:0] idx;
        logic       oneshot;
        logic       lock;
        logic       down;
    } ctrl_t;

    localparam logic [ADDR_W-1:0] A_CTRL_CLR = 3'd0;
    localparam logic [ADDR_W-1:0] A_CTRL_SET = 3'd1;
    localparam logic [ADDR_W-1:0] A_PER_BUF  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CMP_BUF  = 3'd3;
    localparam logic [ADDR_W-1:0] A_PER_ACT  = 3'd4;
    localparam logic [ADDR_W-1:0] A_CMP_ACT  = 3'd5;
    localparam logic [ADDR_W-1:0] A_SNAP     = 3'd6;

endpackage

// File: rtl/tmrsc_presc.sv
`timescale 1ns/1ps
// Prescaler: produces a one-cycle tick once every DIV clock cycles.
// Assumes DIV >= 2. Runs freely out of reset, whatever the counter is doing.
module tmrsc_presc #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] ph_q;

    // Phase counter that wraps after the last phase.
    always_ff @(posedge clk) begin
        if (!rst_n)            ph_q <= '0;
        else if (ph_q == LAST) ph_q <= '0;
        else                   ph_q <= ph_q + PW'(1);
    end

    assign tick = (ph_q == LAST);

    // R6: two ticks are never adjacent, so counting is prescaled.
    a_r6_tick_spaced: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/tmrsc_ctrl.sv
`timescale 1ns/1ps
// Control register reached through a setting alias and a clearing alias.
// Assumes at most one of clr_we/set_we is high per cycle. cmd_taken marks
// the tick on which any queued command is consumed.
module tmrsc_ctrl
    import tmrsc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_we,
    input  logic             set_we,
    input  logic [BUS_W-1:0] wdata,
    input  logic             cmd_taken,
    output ctrl_t            ctrl_q
);
    ctrl_t wr_v;
    ctrl_t nxt;

    assign wr_v = ctrl_t'(wdata);

    // Next-state merge: tick consumption, then alias writes (set has the last word).
    always_comb begin
        nxt = ctrl_q;
        if (cmd_taken) nxt.cmd = '0;
        if (clr_we) begin
            if (wr_v.cmd != '0) nxt.cmd = '0;
            if (wr_v.idx != '0) nxt.idx = '0;
            nxt.oneshot = ctrl_q.oneshot & ~wr_v.oneshot;
            nxt.lock    = ctrl_q.lock    & ~wr_v.lock;
            nxt.down    = ctrl_q.down    & ~wr_v.down;
        end
        if (set_we) begin
            if (wr_v.cmd != '0) nxt.cmd = wr_v.cmd;
            nxt.idx     = ctrl_q.idx     | wr_v.idx;
            nxt.oneshot = ctrl_q.oneshot | wr_v.oneshot;
            nxt.lock    = ctrl_q.lock    | wr_v.lock;
            nxt.down    = ctrl_q.down    | wr_v.down;
        end
    end

    // Register update.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= nxt;
    end

    // R4: a consumed command reads back zero unless a new one was written.
    a_r4_cmd_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_taken && !(set_we && wr_v.cmd != '0)) |=> ctrl_q.cmd == '0);
    // R2: a 1 written to the direction bit through the clearing alias clears it.
    a_r2_clr_down: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && wr_v.down) |=> !ctrl_q.down);
    // R3: a 1 written to the lock bit through the setting alias sets it.
    a_r3_set_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we && wr_v.lock) |=> ctrl_q.lock);
    // R13: a command written through the setting alias survives a same-cycle tick.
    a_r13_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we && wr_v.cmd != '0) |=> ctrl_q.cmd == $past(wr_v.cmd));

endmodule

// File: rtl/tmrsc_core.sv
`timescale 1ns/1ps
// Counter core: buffered period/compare, command execution and wrap events.
// Assumes ctrl is the registered control value and tick the prescaler pulse.
// A downward wrap reloads from the period active before that tick.
module tmrsc_core
    import tmrsc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  ctrl_t            ctrl,
    input  logic             per_we,
    input  logic             cmp_we,
    input  logic [CNT_W-1:0] wval,
    output logic [CNT_W-1:0] cnt_q,
    output logic             running_q,
    output logic [CNT_W-1:0] per_buf_q,
    output logic [CNT_W-1:0] cmp_buf_q,
    output logic [CNT_W-1:0] per_act_q,
    output logic [CNT_W-1:0] cmp_act_q,
    output logic [CNT_W-1:0] snap_q,
    output logic             ovf_q,
    output logic             unf_q
);
    logic [2:0] cmd_now;
    logic       step, wrap_up, wrap_dn, do_copy;

    // Decode the command consumed on this tick and the counting step.
    always_comb begin
        cmd_now = tick ? ctrl.cmd : CMD_NONE;
        step    = tick && running_q && (cmd_now != CMD_RESTART) && (cmd_now != CMD_HALT);
        wrap_up = step && !ctrl.down && (cnt_q >= per_act_q);
        wrap_dn = step &&  ctrl.down && (cnt_q == '0);
        do_copy = ((wrap_up || wrap_dn) && !ctrl.lock) || (cmd_now == CMD_LOAD);
    end

    // Software-written buffers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_buf_q <= '1;
            cmp_buf_q <= '0;
        end else begin
            if (per_we) per_buf_q <= wval;
            if (cmp_we) cmp_buf_q <= wval;
        end
    end

    // Active registers: load from buffers on an unlocked wrap or a load command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_act_q <= '1;
            cmp_act_q <= '0;
        end else if (do_copy) begin
            per_act_q <= per_buf_q;
            cmp_act_q <= cmp_buf_q;
        end
    end

    // Count snapshot taken by the snapshot command.
    always_ff @(posedge clk) begin
        if (!rst_n)                  snap_q <= '0;
        else if (cmd_now == CMD_SNAP) snap_q <= cnt_q;
    end

    // Counter and run state: commands first, then counting with wrap and one-shot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            running_q <= 1'b0;
            ovf_q     <= 1'b0;
            unf_q     <= 1'b0;
        end else begin
            ovf_q <= wrap_up;
            unf_q <= wrap_dn;
            if (cmd_now == CMD_RESTART) begin
                cnt_q     <= ctrl.down ? per_act_q : '0;
                running_q <= 1'b1;
            end else if (cmd_now == CMD_HALT) begin
                running_q <= 1'b0;
            end else if (step) begin
                if (wrap_up)        cnt_q <= '0;
                else if (wrap_dn)   cnt_q <= per_act_q;
                else if (ctrl.down) cnt_q <= cnt_q - CNT_W'(1);
                else                cnt_q <= cnt_q + CNT_W'(1);
                if ((wrap_up || wrap_dn) && ctrl.oneshot) running_q <= 1'b0;
            end
        end
    end

    // R6: the overflow pulse always coincides with a zero count.
    a_r6_ovf_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |-> cnt_q == '0);
    // R6: without a tick the count never moves.
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt_q));
    // R7: the underflow pulse shows the period reloaded.
    a_r7_unf_reload: assert property (@(posedge clk) disable iff (!rst_n)
        unf_q |-> cnt_q == $past(per_act_q));
    // R8: while locked, only the load command may change the active registers.
    a_r8_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.lock && cmd_now != CMD_LOAD) |=> ($stable(per_act_q) && $stable(cmp_act_q)));
    // R9: the load command copies the buffers regardless of the lock.
    a_r9_force_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_now == CMD_LOAD) |=> (per_act_q == $past(per_buf_q) && cmp_act_q == $past(cmp_buf_q)));
    // R10: a wrap with one-shot enabled leaves the counter halted.
    a_r10_oneshot_halt: assert property (@(posedge clk) disable iff (!rst_n)
        ((wrap_up || wrap_dn) && ctrl.oneshot) |=> !running_q);
    // R11: halt stops the counter and keeps the count.
    a_r11_halt_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_now == CMD_HALT) |=> (!running_q && $stable(cnt_q)));
    // R12: the snapshot holds the count present on its tick.
    a_r12_snap_value: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_now == CMD_SNAP) |=> snap_q == $past(cnt_q));

endmodule

// File: rtl/tmrsc_top.sv
`timescale 1ns/1ps
// Top of the set/clear controlled up/down timer.
// Assumes 1 <= CNT_W <= 8 and PRESC_DIV >= 2. Reads are combinational,
// and writes take effect at the clock edge that samples bus_we.
module tmrsc_top
    import tmrsc_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int PRESC_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_waddr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic [ADDR_W-1:0] bus_raddr,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic [CNT_W-1:0]  count_o,
    output logic              running_o,
    output logic              ovf_o,
    output logic              unf_o,
    output logic              tick_o
);
    ctrl_t            ctrl_q;
    logic             tick;
    logic             clr_we, set_we, per_we, cmp_we;
    logic [CNT_W-1:0] per_buf, cmp_buf, per_act, cmp_act, snap;

    // Zero-extend a counter-width value onto the bus.
    function automatic logic [BUS_W-1:0] zext(input logic [CNT_W-1:0] v);
        zext = '0;
        zext[CNT_W-1:0] = v;
    endfunction

    // Write address decode.
    always_comb begin
        clr_we = bus_we && (bus_waddr == A_CTRL_CLR);
        set_we = bus_we && (bus_waddr == A_CTRL_SET);
        per_we = bus_we && (bus_waddr == A_PER_BUF);
        cmp_we = bus_we && (bus_waddr == A_CMP_BUF);
    end

    tmrsc_presc #(.DIV(PRESC_DIV)) i_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    tmrsc_ctrl i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_we    (clr_we),
        .set_we    (set_we),
        .wdata     (bus_wdata),
        .cmd_taken (tick),
        .ctrl_q    (ctrl_q)
    );

    tmrsc_core #(.CNT_W(CNT_W)) i_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .ctrl      (ctrl_q),
        .per_we    (per_we),
        .cmp_we    (cmp_we),
        .wval      (bus_wdata[CNT_W-1:0]),
        .cnt_q     (count_o),
        .running_q (running_o),
        .per_buf_q (per_buf),
        .cmp_buf_q (cmp_buf),
        .per_act_q (per_act),
        .cmp_act_q (cmp_act),
        .snap_q    (snap),
        .ovf_q     (ovf_o),
        .unf_q     (unf_o)
    );

    assign tick_o = tick;

    // Read multiplexer; both control aliases return the same register.
    always_comb begin
        case (bus_raddr)
            A_CTRL_CLR, A_CTRL_SET: bus_rdata = ctrl_q;
            A_PER_BUF:              bus_rdata = zext(per_buf);
            A_CMP_BUF:              bus_rdata = zext(cmp_buf);
            A_PER_ACT:              bus_rdata = zext(per_act);
            A_CMP_ACT:              bus_rdata = zext(cmp_act);
            A_SNAP:                 bus_rdata = zext(snap);
            default:                bus_rdata = '0;
        endcase
    end

    // R6/R7: overflow and underflow never pulse together.
    a_r7_pulse_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_o && unf_o));

endmodule

// File: tb/test_tmrsc_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected values, and the monitor
// compares them 2 ns after each falling edge.
module test_tmrsc_top;

    localparam int K_CNT = 8;
    localparam int K_RUN = 9;
    localparam int K_OVF = 10;
    localparam int K_UNF = 11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [2:0] bus_waddr = '0;
    logic [7:0] bus_wdata = '0;
    logic [2:0] bus_raddr = '0;
    logic [7:0] bus_rdata;
    logic [7:0] count_o;
    logic       running_o, ovf_o, unf_o, tick_o;

    typedef struct {
        int         kind;
        logic [7:0] exp;
        string      tag;
    } sb_item_t;

    sb_item_t sbq[$];
    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    tmrsc_top #(.CNT_W(8), .PRESC_DIV(4)) i_tmrsc_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_waddr (bus_waddr),
        .bus_wdata (bus_wdata),
        .bus_raddr (bus_raddr),
        .bus_rdata (bus_rdata),
        .count_o   (count_o),
        .running_o (running_o),
        .ovf_o     (ovf_o),
        .unf_o     (unf_o),
        .tick_o    (tick_o)
    );

    task automatic expect_v(input int kind, input logic [7:0] v, input string tag);
        sb_item_t it;
        it.kind = kind;
        it.exp  = v;
        it.tag  = tag;
        sbq.push_back(it);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_we    = 1'b1;
        bus_waddr = a;
        bus_wdata = d;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    // Return at the falling edge just after the next count edge.
    task automatic tick_edge();
        while (tick_o !== 1'b1) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick_edge();
    endtask

    // Monitor: pop and compare every item queued at this falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sbq.size() > 0) begin
                sb_item_t   it;
                logic [7:0] act;
                it = sbq.pop_front();
                case (it.kind)
                    K_CNT:   act = count_o;
                    K_RUN:   act = {7'd0, running_o};
                    K_OVF:   act = {7'd0, ovf_o};
                    K_UNF:   act = {7'd0, unf_o};
                    default: begin
                        bus_raddr = 3'(it.kind);
                        #1;
                        act = bus_rdata;
                    end
                endcase
                n_checks++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s kind=%0d actual=0x%02h expected=0x%02h",
                             it.tag, it.kind, act, it.exp);
                end
            end
        end
    end

    // Driver: stimulus and expected values derived from the requirements.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_v(0, 8'h00, "R1");
        expect_v(1, 8'h00, "R1");
        expect_v(K_CNT, 8'd0, "R1");
        expect_v(K_RUN, 8'd0, "R1");
        expect_v(4, 8'hFF, "R1");
        expect_v(5, 8'h00, "R1");

        // R9: buffers do not reach active registers before a copy.
        tick_edge();
        wr(3'd2, 8'd5);
        wr(3'd3, 8'd3);
        expect_v(2, 8'd5, "R9");
        expect_v(4, 8'hFF, "R9");
        tick_edge();
        wr(3'd1, 8'h60);
        expect_v(1, 8'h60, "R3");
        tick_edge();
        expect_v(0, 8'h00, "R4");
        expect_v(4, 8'd5, "R9");
        expect_v(5, 8'd3, "R9");

        // R11 restart, R6 upward count and wrap.
        wr(3'd1, 8'h20);
        tick_edge();
        expect_v(K_CNT, 8'd0, "R11");
        expect_v(K_RUN, 8'd1, "R11");
        ticks(5);
        expect_v(K_CNT, 8'd5, "R6");
        expect_v(K_OVF, 8'd0, "R6");
        tick_edge();
        expect_v(K_CNT, 8'd0, "R6");
        expect_v(K_OVF, 8'd1, "R6");
        @(negedge clk);
        expect_v(K_OVF, 8'd0, "R6");

        // R8: locked wrap keeps period, unlocked wrap copies it.
        wr(3'd1, 8'h02);
        wr(3'd2, 8'd7);
        expect_v(0, 8'h02, "R3");
        ticks(6);
        expect_v(K_OVF, 8'd1, "R8");
        expect_v(4, 8'd5, "R8");
        wr(3'd0, 8'h02);
        expect_v(1, 8'h00, "R2");
        ticks(6);
        expect_v(K_OVF, 8'd1, "R8");
        expect_v(4, 8'd7, "R8");

        // R7: downward count and underflow reload.
        wr(3'd1, 8'h01);
        expect_v(0, 8'h01, "R3");
        tick_edge();
        expect_v(K_CNT, 8'd7, "R7");
        expect_v(K_UNF, 8'd1, "R7");
        ticks(3);
        expect_v(K_CNT, 8'd4, "R7");

        // R10: one-shot halts after the next underflow.
        wr(3'd1, 8'h04);
        expect_v(1, 8'h05, "R3");
        ticks(4);
        expect_v(K_CNT, 8'd0, "R10");
        expect_v(K_RUN, 8'd1, "R10");
        tick_edge();
        expect_v(K_CNT, 8'd7, "R10");
        expect_v(K_RUN, 8'd0, "R10");
        expect_v(K_UNF, 8'd1, "R10");
        ticks(2);
        expect_v(K_CNT, 8'd7, "R10");

        // R11: restart downward, then halt keeps the count.
        wr(3'd0, 8'h04);
        wr(3'd1, 8'h20);
        tick_edge();
        expect_v(K_CNT, 8'd7, "R11");
        expect_v(K_RUN, 8'd1, "R11");
        tick_edge();
        wr(3'd1, 8'h40);
        tick_edge();
        expect_v(K_RUN, 8'd0, "R11");
        expect_v(K_CNT, 8'd6, "R11");
        ticks(2);
        expect_v(K_CNT, 8'd6, "R11");

        // R4: cancel a queued restart through the clearing alias.
        wr(3'd1, 8'h20);
        expect_v(0, 8'h21, "R4");
        wr(3'd0, 8'hE0);
        expect_v(1, 8'h01, "R4");
        tick_edge();
        expect_v(K_RUN, 8'd0, "R4");
        expect_v(K_CNT, 8'd6, "R4");

        // R2: zero writes to either alias change nothing.
        wr(3'd1, 8'h06);
        expect_v(0, 8'h07, "R3");
        wr(3'd0, 8'h00);
        expect_v(1, 8'h07, "R2");
        tick_edge();
        wr(3'd1, 8'h00);
        expect_v(0, 8'h07, "R2");
        wr(3'd0, 8'h07);
        expect_v(0, 8'h00, "R2");

        // R5: index field set and clear.
        tick_edge();
        wr(3'd1, 8'h18);
        expect_v(0, 8'h18, "R5");
        wr(3'd0, 8'h08);
        expect_v(1, 8'h00, "R5");

        // R12 and R13: snapshot runs on a tick that also receives a restart write.
        tick_edge();
        wr(3'd1, 8'h20);
        tick_edge();
        expect_v(K_CNT, 8'd0, "R11");
        ticks(3);
        expect_v(K_CNT, 8'd3, "R6");
        wr(3'd1, 8'h80);
        expect_v(0, 8'h80, "R3");
        while (tick_o !== 1'b1) @(negedge clk);
        wr(3'd1, 8'h20);
        expect_v(6, 8'd3, "R12");
        expect_v(K_CNT, 8'd4, "R13");
        expect_v(0, 8'h20, "R13");
        tick_edge();
        expect_v(K_CNT, 8'd0, "R13");
        expect_v(1, 8'h00, "R13");
        expect_v(K_RUN, 8'd1, "R13");

        @(negedge clk);
        #5;
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule